// File: doc/BRIEF.md
# Speculative Indirect-Branch Path History

This block keeps, for each hardware thread, an ordered record of the indirect branches that the front end has predicted but not yet discarded. Each record holds the branch address, the branch target and the instruction sequence number. Records are added at the young end as branches are predicted. Commit retires them from the old end. A flush removes every record younger than a given sequence number. After a misprediction, the target of the youngest record can be corrected.

Retired records are not freed at once. A retire pointer counts committed records from the old end. The oldest record is only released once that pointer has moved past the path length. This means the index hash of the target cache still sees the targets of branches that have already retired. The block shows the most recent path-length targets of one selected thread, youngest first, with a valid bit per slot. It can leave out the youngest record, which is needed when the hash must be computed for that record's own target correction.

Top module: `path_hist_buf`

## Requirements
- R1: While `rst_n` is low at a clock edge, every thread becomes empty. After that edge `view_count`, `view_head`, `path_valid` and `overflow` are all zero.
- R2: A record operation appends one entry (address, target, sequence number) at the young end of its thread. After the edge, `young_addr`/`young_seq` show that entry and `view_count` has grown by one.
- R3: A record to a thread that already holds `DEPTH` entries is discarded and that thread's contents are unchanged. The thread's bit of `overflow` is high for exactly the one cycle that follows such a record.
- R4: A commit with sequence number S has no effect if the thread is empty, if the retire pointer is not below the entry count, or if the entry at the retire pointer has a sequence number greater than S. Sequence numbers are compared as unsigned values.
- R5: A commit that passes those checks while the retire pointer (`view_head`) is below `PATH_LEN` increments the pointer by one and keeps every entry.
- R6: A commit that passes those checks while the retire pointer is at least `PATH_LEN` drops the oldest entry. The count falls by one and the pointer value is unchanged.
- R7: A squash with sequence number S finds the oldest entry whose sequence number exceeds S, then removes that entry and every younger one. The retire pointer is not changed. With no such entry, nothing is removed.
- R8: A target correction replaces only the target of the thread's youngest entry. Its address and sequence number stay unchanged. On an empty thread the correction has no effect.
- R9: Operations on one thread in the same cycle take effect in this order: squash, then correction, then commit, then record.
- R10: Output slot p of `path_target` (bits `[p*ADDR_W +: ADDR_W]`) carries the target of the p-th youngest entry of the thread selected by `view_tid`. Slot 0 is the youngest entry. `path_valid[p]` is 1 exactly when that entry exists, and an invalid slot reads zero. `young_addr`/`young_seq` read zero for an empty thread.
- R11: With `view_skip_young` high, the path slots start from the second-youngest entry. `young_addr`, `young_seq`, `view_count` and `view_head` are unaffected.
- R12: Each operation acts only on the thread named by its own thread-ID input. Other threads keep their contents, pointers and overflow state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rec_valid | input | 1 | Append a new entry |
| rec_tid | input | TID_W | Thread of the append |
| rec_addr | input | ADDR_W | Branch address of the new entry |
| rec_target | input | ADDR_W | Predicted target of the new entry |
| rec_seq | input | SEQ_W | Sequence number of the new entry |
| cmt_valid | input | 1 | Commit request |
| cmt_tid | input | TID_W | Thread of the commit |
| cmt_seq | input | SEQ_W | Sequence number being committed |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread of the squash |
| sq_seq | input | SEQ_W | Last surviving sequence number |
| fix_valid | input | 1 | Correct the youngest target |
| fix_tid | input | TID_W | Thread of the correction |
| fix_target | input | ADDR_W | Resolved target |
| view_tid | input | TID_W | Thread shown on the view outputs |
| view_skip_young | input | 1 | Leave the youngest entry out of the path slots |
| path_target | output | PATH_LEN*ADDR_W | Path targets, youngest in slot 0 |
| path_valid | output | PATH_LEN | Per-slot valid |
| young_addr | output | ADDR_W | Address of the youngest entry |
| young_seq | output | SEQ_W | Sequence number of the youngest entry |
| view_count | output | $clog2(DEPTH+1) | Entries held by the viewed thread |
| view_head | output | $clog2(DEPTH+1) | Retire pointer of the viewed thread |
| overflow | output | NUM_THREADS | Per-thread pulse after a discarded record |

## Verification
All state is in registers and every view output is a combinational function of that state. A wrong ring base, count or retire pointer is therefore visible in the cycle right after the faulty edge. It shows up in `view_count`, `view_head` or a shifted set of path slots. A misplaced data write can stay hidden, because a slot that is corrupted but out of view shows nothing until later appends or squashes bring it into the path window or make it the youngest entry. For that reason the random phase keeps squashing back over older entries and switching the viewed thread, so that buried slots are brought to the ports.

// File: rtl/path_hist_pkg.sv
// Package: default geometry shared by the path history modules.
// Assumes the ring depth is a power of two and larger than the path length.
package path_hist_pkg;
    localparam int PH_THREADS_DEF = 2;
    localparam int PH_DEPTH_DEF   = 16;
    localparam int PH_PATH_DEF    = 3;
    localparam int PH_ADDR_W_DEF  = 32;
    localparam int PH_SEQ_W_DEF   = 16;

    // Order in which same-cycle operations on one thread are applied.
    typedef enum logic [1:0] {
        PH_STEP_SQUASH = 2'd0,
        PH_STEP_FIX    = 2'd1,
        PH_STEP_COMMIT = 2'd2,
        PH_STEP_RECORD = 2'd3
    } ph_step_e;
endpackage

// File: rtl/path_hist_scan.sv
// Module: path_hist_scan
// Finds how many entries survive a squash: the position, counted from the
// oldest entry, of the first entry whose sequence number exceeds the bound.
// If no such entry exists, the current count is returned.
// Assumes DEPTH is a power of two, so ring positions wrap by truncation.
module path_hist_scan #(
    parameter int DEPTH = path_hist_pkg::PH_DEPTH_DEF,
    parameter int SEQ_W = path_hist_pkg::PH_SEQ_W_DEF,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
    input  logic [IDX_W-1:0]            base_i,
    input  logic [CNT_W-1:0]            cnt_i,
    input  logic [SEQ_W-1:0]            bound_i,
    output logic [CNT_W-1:0]            keep_o
);
    logic [DEPTH-1:0] younger;

    // Mark live entries (by age position) that lie beyond the squash point.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            younger[i] = (CNT_W'(i) < cnt_i) &&
                         (seq_i[base_i + IDX_W'(i)] > bound_i);
        end
    end

    // Priority-encode the oldest marked position.
    always_comb begin
        keep_o = cnt_i;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (younger[i]) keep_o = CNT_W'(i);
        end
    end
endmodule

// File: rtl/path_hist_lane.sv
// Module: path_hist_lane
// One thread's history ring. Holds base (oldest slot), count and retire
// pointer. It applies squash, correction, commit and record in that order
// within one cycle. Assumes DEPTH is a power of two and PATH_LEN < DEPTH.
// Payload storage is not reset; validity is carried by the count.
module path_hist_lane #(
    parameter int DEPTH    = path_hist_pkg::PH_DEPTH_DEF,
    parameter int PATH_LEN = path_hist_pkg::PH_PATH_DEF,
    parameter int ADDR_W   = path_hist_pkg::PH_ADDR_W_DEF,
    parameter int SEQ_W    = path_hist_pkg::PH_SEQ_W_DEF,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rec_en,
    input  logic [ADDR_W-1:0]            rec_addr,
    input  logic [ADDR_W-1:0]            rec_tgt,
    input  logic [SEQ_W-1:0]             rec_seq,
    input  logic                         cmt_en,
    input  logic [SEQ_W-1:0]             cmt_seq,
    input  logic                         sq_en,
    input  logic [SEQ_W-1:0]             sq_seq,
    input  logic                         fix_en,
    input  logic [ADDR_W-1:0]            fix_tgt,
    output logic [IDX_W-1:0]             base_o,
    output logic [CNT_W-1:0]             cnt_o,
    output logic [CNT_W-1:0]             head_o,
    output logic [DEPTH-1:0][ADDR_W-1:0] tgt_o,
    output logic [DEPTH-1:0][ADDR_W-1:0] addr_o,
    output logic [DEPTH-1:0][SEQ_W-1:0]  seq_o,
    output logic                         ovf_o
);
    logic [IDX_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q, head_q;
    logic             ovf_q;
    logic [DEPTH-1:0][ADDR_W-1:0] tgt_q, addr_q;
    logic [DEPTH-1:0][SEQ_W-1:0]  seq_q;

    logic [CNT_W-1:0] keep_cnt, sq_cnt, cm_cnt, cnt_n, head_n;
    logic [IDX_W-1:0] fix_slot, rec_slot, cm_base;
    logic             fix_do, cmt_ok, cmt_drop, cmt_adv, rec_full, rec_do;
    logic [SEQ_W-1:0] head_seq;

    path_hist_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) scan_i (
        .seq_i   (seq_q),
        .base_i  (base_q),
        .cnt_i   (cnt_q),
        .bound_i (sq_seq),
        .keep_o  (keep_cnt)
    );

    // Step 1: squash truncates the young end.
    assign sq_cnt = sq_en ? keep_cnt : cnt_q;

    // Step 2: correction targets the youngest survivor of the squash.
    assign fix_do   = fix_en && (sq_cnt != '0);
    assign fix_slot = base_q + IDX_W'(sq_cnt - CNT_W'(1));

    // Step 3: commit examines the entry at the retire pointer.
    assign head_seq = seq_q[base_q + IDX_W'(head_q)];
    assign cmt_ok   = cmt_en && (sq_cnt != '0) && (head_q < sq_cnt) &&
                      (head_seq <= cmt_seq);
    assign cmt_drop = cmt_ok && (head_q >= CNT_W'(PATH_LEN));
    assign cmt_adv  = cmt_ok && !cmt_drop;
    assign cm_base  = base_q + IDX_W'(cmt_drop);
    assign cm_cnt   = sq_cnt - CNT_W'(cmt_drop);
    assign head_n   = head_q + CNT_W'(cmt_adv);

    // Step 4: record appends unless the ring is full.
    assign rec_full = (cm_cnt == CNT_W'(DEPTH));
    assign rec_do   = rec_en && !rec_full;
    assign rec_slot = cm_base + IDX_W'(cm_cnt);
    assign cnt_n    = cm_cnt + CNT_W'(rec_do);

    // Control registers: ring base, count, retire pointer, overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            head_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            base_q <= cm_base;
            cnt_q  <= cnt_n;
            head_q <= head_n;
            ovf_q  <= rec_en && rec_full;
        end
    end

    // One storage slot per ring position; a record write wins over a correction.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rec_do && (rec_slot == IDX_W'(g))) begin
                tgt_q[g]  <= rec_tgt;
                addr_q[g] <= rec_addr;
                seq_q[g]  <= rec_seq;
            end else if (fix_do && (fix_slot == IDX_W'(g))) begin
                tgt_q[g]  <= fix_tgt;
            end
        end
    end

    assign base_o = base_q;
    assign cnt_o  = cnt_q;
    assign head_o = head_q;
    assign tgt_o  = tgt_q;
    assign addr_o = addr_q;
    assign seq_o  = seq_q;
    assign ovf_o  = ovf_q;
endmodule

// File: rtl/path_hist_view.sv
// Module: path_hist_view
// Extracts the youngest PATH_LEN targets of one ring, youngest first,
// optionally leaving out the youngest entry, and reports that youngest entry.
// Slots without an entry read zero. Purely combinational.
module path_hist_view #(
    parameter int DEPTH    = path_hist_pkg::PH_DEPTH_DEF,
    parameter int PATH_LEN = path_hist_pkg::PH_PATH_DEF,
    parameter int ADDR_W   = path_hist_pkg::PH_ADDR_W_DEF,
    parameter int SEQ_W    = path_hist_pkg::PH_SEQ_W_DEF,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0]    tgt_i,
    input  logic [DEPTH-1:0][ADDR_W-1:0]    addr_i,
    input  logic [DEPTH-1:0][SEQ_W-1:0]     seq_i,
    input  logic [IDX_W-1:0]                base_i,
    input  logic [CNT_W-1:0]                cnt_i,
    input  logic                            skip_i,
    output logic [PATH_LEN-1:0][ADDR_W-1:0] path_o,
    output logic [PATH_LEN-1:0]             vld_o,
    output logic [ADDR_W-1:0]               young_addr_o,
    output logic [SEQ_W-1:0]                young_seq_o
);
    logic [CNT_W-1:0] eff_cnt;
    logic [IDX_W-1:0] young_slot;
    logic             has_any;

    // Number of entries eligible for the path window.
    assign has_any = (cnt_i != '0);
    assign eff_cnt = (skip_i && has_any) ? cnt_i - CNT_W'(1) : cnt_i;

    // Youngest entry, reported whether or not it is skipped.
    assign young_slot   = base_i + IDX_W'(cnt_i - CNT_W'(1));
    assign young_addr_o = has_any ? addr_i[young_slot] : '0;
    assign young_seq_o  = has_any ? seq_i[young_slot]  : '0;

    // One window slot per path position, counted back from the young end.
    for (genvar p = 0; p < PATH_LEN; p++) begin : g_path
        logic [IDX_W-1:0] slot;
        assign vld_o[p]  = (CNT_W'(p) < eff_cnt);
        assign slot      = base_i + IDX_W'(eff_cnt - CNT_W'(p) - CNT_W'(1));
        assign path_o[p] = vld_o[p] ? tgt_i[slot] : '0;
    end
endmodule

// File: rtl/path_hist_buf.sv
// Module: path_hist_buf (top)
// Per-thread speculative history of indirect branches. Every operation
// carries a thread ID and is steered to that thread's lane. The view outputs
// show the lane picked by view_tid. Assumes DEPTH is a power of two,
// 1 <= PATH_LEN < DEPTH, and sequence numbers that do not wrap.
module path_hist_buf #(
    parameter int NUM_THREADS = path_hist_pkg::PH_THREADS_DEF,
    parameter int DEPTH       = path_hist_pkg::PH_DEPTH_DEF,
    parameter int PATH_LEN    = path_hist_pkg::PH_PATH_DEF,
    parameter int ADDR_W      = path_hist_pkg::PH_ADDR_W_DEF,
    parameter int SEQ_W       = path_hist_pkg::PH_SEQ_W_DEF,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rec_valid,
    input  logic [TID_W-1:0]           rec_tid,
    input  logic [ADDR_W-1:0]          rec_addr,
    input  logic [ADDR_W-1:0]          rec_target,
    input  logic [SEQ_W-1:0]           rec_seq,
    input  logic                       cmt_valid,
    input  logic [TID_W-1:0]           cmt_tid,
    input  logic [SEQ_W-1:0]           cmt_seq,
    input  logic                       sq_valid,
    input  logic [TID_W-1:0]           sq_tid,
    input  logic [SEQ_W-1:0]           sq_seq,
    input  logic                       fix_valid,
    input  logic [TID_W-1:0]           fix_tid,
    input  logic [ADDR_W-1:0]          fix_target,
    input  logic [TID_W-1:0]           view_tid,
    input  logic                       view_skip_young,
    output logic [PATH_LEN*ADDR_W-1:0] path_target,
    output logic [PATH_LEN-1:0]        path_valid,
    output logic [ADDR_W-1:0]          young_addr,
    output logic [SEQ_W-1:0]           young_seq,
    output logic [CNT_W-1:0]           view_count,
    output logic [CNT_W-1:0]           view_head,
    output logic [NUM_THREADS-1:0]     overflow
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0]             lane_base [NUM_THREADS];
    logic [CNT_W-1:0]             lane_cnt  [NUM_THREADS];
    logic [CNT_W-1:0]             lane_head [NUM_THREADS];
    logic [DEPTH-1:0][ADDR_W-1:0] lane_tgt  [NUM_THREADS];
    logic [DEPTH-1:0][ADDR_W-1:0] lane_addr [NUM_THREADS];
    logic [DEPTH-1:0][SEQ_W-1:0]  lane_seq  [NUM_THREADS];

    // One lane per thread; each operation is qualified by its own thread ID.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lane
        path_hist_lane #(
            .DEPTH(DEPTH), .PATH_LEN(PATH_LEN), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .rec_en   (rec_valid && (rec_tid == TID_W'(t))),
            .rec_addr (rec_addr),
            .rec_tgt  (rec_target),
            .rec_seq  (rec_seq),
            .cmt_en   (cmt_valid && (cmt_tid == TID_W'(t))),
            .cmt_seq  (cmt_seq),
            .sq_en    (sq_valid && (sq_tid == TID_W'(t))),
            .sq_seq   (sq_seq),
            .fix_en   (fix_valid && (fix_tid == TID_W'(t))),
            .fix_tgt  (fix_target),
            .base_o   (lane_base[t]),
            .cnt_o    (lane_cnt[t]),
            .head_o   (lane_head[t]),
            .tgt_o    (lane_tgt[t]),
            .addr_o   (lane_addr[t]),
            .seq_o    (lane_seq[t]),
            .ovf_o    (overflow[t])
        );
    end

    // Select the viewed lane; an out-of-range ID falls back to lane 0.
    logic [TID_W-1:0] sel;
    assign sel = (32'(view_tid) < NUM_THREADS) ? view_tid : '0;

    logic [PATH_LEN-1:0][ADDR_W-1:0] path_w;

    path_hist_view #(
        .DEPTH(DEPTH), .PATH_LEN(PATH_LEN), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
    ) view_i (
        .tgt_i        (lane_tgt[sel]),
        .addr_i       (lane_addr[sel]),
        .seq_i        (lane_seq[sel]),
        .base_i       (lane_base[sel]),
        .cnt_i        (lane_cnt[sel]),
        .skip_i       (view_skip_young),
        .path_o       (path_w),
        .vld_o        (path_valid),
        .young_addr_o (young_addr),
        .young_seq_o  (young_seq)
    );

    assign path_target = path_w;
    assign view_count  = lane_cnt[sel];
    assign view_head   = lane_head[sel];
endmodule

// File: rtl/path_hist_buf_chk.sv
// Module: path_hist_buf_chk
// Temporal checks on the ports of path_hist_buf, attached by bind below.
module path_hist_buf_chk #(
    parameter int NUM_THREADS = 2,
    parameter int DEPTH       = 16,
    parameter int PATH_LEN    = 3,
    parameter int ADDR_W      = 32,
    parameter int SEQ_W       = 16,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rec_valid,
    input logic [TID_W-1:0]       rec_tid,
    input logic                   sq_valid,
    input logic [TID_W-1:0]       view_tid,
    input logic [PATH_LEN-1:0]    path_valid,
    input logic [ADDR_W-1:0]      young_addr,
    input logic [SEQ_W-1:0]       young_seq,
    input logic [CNT_W-1:0]       view_count,
    input logic [CNT_W-1:0]       view_head,
    input logic [NUM_THREADS-1:0] overflow
);
    // R1: reset empties the viewed thread and clears every pulse.
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (view_count == '0) && (view_head == '0) &&
                   (path_valid == '0) && (overflow == '0));

    // R2: the count grows by at most one entry per cycle.
    a_r2_single_append: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(view_tid) |-> (view_count <= $past(view_count) + CNT_W'(1)));

    // R3: an overflow pulse needs a record for that thread one cycle earlier.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ovf
        a_r3_ovf_after_record: assert property (@(posedge clk) disable iff (!rst_n)
            overflow[t] |-> ($past(rec_valid) && ($past(rec_tid) == TID_W'(t))));
    end

    // R3: the count never exceeds the ring depth.
    a_r3_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        view_count <= CNT_W'(DEPTH));

    // R5: the retire pointer only ever holds or steps by one.
    a_r5_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(view_tid) && (view_head != $past(view_head))) |->
        (view_head == $past(view_head) + CNT_W'(1)));

    // R8: without append or squash, the youngest entry keeps address and number.
    a_r8_young_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(view_tid) && $past(!rec_valid && !sq_valid)) |->
        ($stable(young_addr) && $stable(young_seq)));

    // R10: valid slots form a contiguous run starting at slot 0.
    a_r10_valid_packed: assert property (@(posedge clk) disable iff (!rst_n)
        (path_valid & (path_valid + PATH_LEN'(1))) == '0);
endmodule

bind path_hist_buf path_hist_buf_chk #(
    .NUM_THREADS(NUM_THREADS), .DEPTH(DEPTH), .PATH_LEN(PATH_LEN),
    .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rec_valid  (rec_valid),
    .rec_tid    (rec_tid),
    .sq_valid   (sq_valid),
    .view_tid   (view_tid),
    .path_valid (path_valid),
    .young_addr (young_addr),
    .young_seq  (young_seq),
    .view_count (view_count),
    .view_head  (view_head),
    .overflow   (overflow)
);

// File: tb/path_hist_buf_tb_top.sv
`timescale 1ns/1ps
module path_hist_buf_tb_top;
    localparam int NT = 2;
    localparam int DEPTH = 16;
    localparam int PL = 3;
    localparam int AW = 32;
    localparam int SW = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_valid = 0, cmt_valid = 0, sq_valid = 0, fix_valid = 0;
    logic rec_tid = 0, cmt_tid = 0, sq_tid = 0, fix_tid = 0, view_tid = 0;
    logic view_skip_young = 0;
    logic [AW-1:0] rec_addr = '0, rec_target = '0, fix_target = '0;
    logic [SW-1:0] rec_seq = '0, cmt_seq = '0, sq_seq = '0;
    logic [PL*AW-1:0] path_target;
    logic [PL-1:0]    path_valid;
    logic [AW-1:0]    young_addr;
    logic [SW-1:0]    young_seq;
    logic [CW-1:0]    view_count, view_head;
    logic [NT-1:0]    overflow;

    always #2.5 clk = ~clk;

    path_hist_buf #(
        .NUM_THREADS(NT), .DEPTH(DEPTH), .PATH_LEN(PL), .ADDR_W(AW), .SEQ_W(SW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rec_valid(rec_valid), .rec_tid(rec_tid), .rec_addr(rec_addr),
        .rec_target(rec_target), .rec_seq(rec_seq),
        .cmt_valid(cmt_valid), .cmt_tid(cmt_tid), .cmt_seq(cmt_seq),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .fix_valid(fix_valid), .fix_tid(fix_tid), .fix_target(fix_target),
        .view_tid(view_tid), .view_skip_young(view_skip_young),
        .path_target(path_target), .path_valid(path_valid),
        .young_addr(young_addr), .young_seq(young_seq),
        .view_count(view_count), .view_head(view_head), .overflow(overflow)
    );

    // Reference model: index 0 is the oldest entry of each thread.
    logic [AW-1:0] m_addr [NT][DEPTH];
    logic [AW-1:0] m_tgt  [NT][DEPTH];
    logic [SW-1:0] m_seq  [NT][DEPTH];
    int            m_cnt  [NT];
    int            m_head [NT];
    logic          m_ovf  [NT];
    int            nseq   [NT];

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_cnt[t] = 0; m_head[t] = 0; m_ovf[t] = 0; nseq[t] = 0;
        end
    endtask

    // Apply one cycle of operations: squash, correction, commit, record.
    task automatic model_step();
        for (int t = 0; t < NT; t++) begin
            m_ovf[t] = 0;
            if (sq_valid && sq_tid == t[0]) begin
                int k = m_cnt[t];
                for (int i = m_cnt[t] - 1; i >= 0; i--)
                    if (m_seq[t][i] > sq_seq) k = i;
                m_cnt[t] = k;
            end
            if (fix_valid && fix_tid == t[0] && m_cnt[t] > 0)
                m_tgt[t][m_cnt[t]-1] = fix_target;
            if (cmt_valid && cmt_tid == t[0] && m_cnt[t] > 0 &&
                m_head[t] < m_cnt[t] && m_seq[t][m_head[t]] <= cmt_seq) begin
                if (m_head[t] >= PL) begin
                    for (int i = 0; i < DEPTH - 1; i++) begin
                        m_addr[t][i] = m_addr[t][i+1];
                        m_tgt[t][i]  = m_tgt[t][i+1];
                        m_seq[t][i]  = m_seq[t][i+1];
                    end
                    m_cnt[t]--;
                end else begin
                    m_head[t]++;
                end
            end
            if (rec_valid && rec_tid == t[0]) begin
                if (m_cnt[t] == DEPTH) m_ovf[t] = 1;
                else begin
                    m_addr[t][m_cnt[t]] = rec_addr;
                    m_tgt[t][m_cnt[t]]  = rec_target;
                    m_seq[t][m_cnt[t]]  = rec_seq;
                    m_cnt[t]++;
                end
            end
        end
    endtask

    // Compare every view output and both overflow bits with the model.
    task automatic check_all(string req);
        int t = int'(view_tid);
        int c = m_cnt[t];
        int eff = (view_skip_young && c > 0) ? c - 1 : c;
        chk(req, "count", 64'(view_count), 64'(c));
        chk(req, "head", 64'(view_head), 64'(m_head[t]));
        chk(req, "young_addr", 64'(young_addr), (c > 0) ? 64'(m_addr[t][c-1]) : 64'd0);
        chk(req, "young_seq", 64'(young_seq), (c > 0) ? 64'(m_seq[t][c-1]) : 64'd0);
        for (int p = 0; p < PL; p++) begin
            chk(req, "slot_valid", 64'(path_valid[p]), 64'(p < eff));
            chk(req, "slot_target", 64'(path_target[p*AW +: AW]),
                (p < eff) ? 64'(m_tgt[t][eff-1-p]) : 64'd0);
        end
        for (int u = 0; u < NT; u++)
            chk(req, "overflow", 64'(overflow[u]), 64'(m_ovf[u]));
    endtask

    task automatic clear_ops();
        rec_valid = 0; cmt_valid = 0; sq_valid = 0; fix_valid = 0;
    endtask

    // Inputs are set at a falling edge; the model follows the rising edge and
    // the outputs are compared at the next falling edge.
    task automatic tick(string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(req);
        clear_ops();
    endtask

    task automatic do_rec(bit t, int a, int tg, int s, string req);
        rec_valid = 1; rec_tid = t; rec_addr = AW'(a); rec_target = AW'(tg);
        rec_seq = SW'(s); view_tid = t;
        if (s > nseq[t]) nseq[t] = s;
        tick(req);
    endtask

    task automatic do_cmt(bit t, int s, string req);
        cmt_valid = 1; cmt_tid = t; cmt_seq = SW'(s); view_tid = t; tick(req);
    endtask

    task automatic do_sq(bit t, int s, string req);
        sq_valid = 1; sq_tid = t; sq_seq = SW'(s); view_tid = t; tick(req);
    endtask

    task automatic do_fix(bit t, int tg, string req);
        fix_valid = 1; fix_tid = t; fix_target = AW'(tg); view_tid = t; tick(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no finish, expected end of run");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        model_reset();
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R1: outputs after synchronous reset.
        view_tid = 0; check_all("R1");
        view_tid = 1; check_all("R1");
        rst_n = 1;

        // R2 / R10: append four entries, view youngest first.
        do_rec(0, 'h100, 'h1000, 10, "R2");
        do_rec(0, 'h104, 'h2000, 20, "R2");
        do_rec(0, 'h108, 'h3000, 30, "R10");
        do_rec(0, 'h10c, 'h4000, 40, "R10");
        // R11: leave out the youngest.
        view_skip_young = 1; tick("R11"); view_skip_young = 0;
        // R8: correct youngest target; correction on empty thread 1.
        do_fix(0, 'h4444, "R8");
        do_fix(1, 'h9999, "R8");
        // R4 / R5 / R6: commit sequence.
        do_cmt(0, 5, "R4");
        do_cmt(0, 10, "R5");
        do_cmt(0, 20, "R5");
        do_cmt(0, 30, "R5");
        do_cmt(0, 40, "R6");
        do_cmt(0, 50, "R4");
        // R7: squash back over the young end.
        do_rec(0, 'h110, 'h5000, 50, "R2");
        do_rec(0, 'h114, 'h6000, 60, "R2");
        do_rec(0, 'h118, 'h7000, 70, "R2");
        do_sq(0, 55, "R7");
        do_sq(0, 99, "R7");
        // R9: all four operations in one cycle.
        sq_valid = 1; sq_tid = 0; sq_seq = 45;
        fix_valid = 1; fix_tid = 0; fix_target = 'hABCD;
        cmt_valid = 1; cmt_tid = 0; cmt_seq = 45;
        rec_valid = 1; rec_tid = 0; rec_addr = 'h200; rec_target = 'hBEEF; rec_seq = 80;
        nseq[0] = 80; view_tid = 0;
        tick("R9");
        // R3 / R12: fill thread 1 while viewing thread 0, then overflow it.
        for (int i = 0; i < DEPTH; i++) begin
            rec_valid = 1; rec_tid = 1; rec_addr = AW'('h300 + i);
            rec_target = AW'('h8000 + i); rec_seq = SW'(100 + i); view_tid = 0;
            tick("R12");
        end
        nseq[1] = 100 + DEPTH;
        do_rec(1, 'h3ff, 'hdead, 200, "R3");
        tick("R3");

        // Mixed random phase over both threads.
        for (int n = 0; n < 4000; n++) begin
            int t;
            if ($urandom_range(0, 99) < 45) begin
                t = $urandom_range(0, NT - 1);
                nseq[t] += $urandom_range(1, 3);
                rec_valid = 1; rec_tid = t[0]; rec_addr = $urandom; rec_target = $urandom;
                rec_seq = SW'(nseq[t]);
            end
            if ($urandom_range(0, 99) < 35) begin
                t = $urandom_range(0, NT - 1);
                cmt_valid = 1; cmt_tid = t[0];
                if (m_cnt[t] > 0) begin
                    int h = (m_head[t] < m_cnt[t]) ? m_head[t] : m_cnt[t] - 1;
                    int s = int'(m_seq[t][h]) + $urandom_range(0, 3) - 1;
                    cmt_seq = SW'((s < 0) ? 0 : s);
                end else cmt_seq = $urandom;
            end
            if ($urandom_range(0, 99) < 12) begin
                int s;
                t = $urandom_range(0, NT - 1);
                s = nseq[t] - $urandom_range(0, 14);
                sq_valid = 1; sq_tid = t[0]; sq_seq = SW'((s < 0) ? 0 : s);
            end
            if ($urandom_range(0, 99) < 15) begin
                fix_valid = 1; fix_tid = $urandom_range(0, NT - 1); fix_target = $urandom;
            end
            view_tid = $urandom_range(0, NT - 1);
            view_skip_young = $urandom_range(0, 1);
            tick((n % 2 == 0) ? "R9" : "R12");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule